// File: doc/BRIEF.md
# Block Move and Compare Sequencer

This block runs memory block operations for a processor core: it copies a run of elements from a source pointer to a destination pointer, or scans a run of elements and compares each one against an accumulator. Each operation comes in a one-element form and a repeating form. Each runs upward or downward through memory, and each works on bytes or on 16-bit words. The block holds its own pointer registers, element counter, accumulator and flag register. A small idle-time configuration port loads these registers. The block drives a simple read/write memory port whose read data is returned combinationally in the same cycle.

An operation begins with a one-cycle `start` pulse. The pulse carries the operation kind, the repeat, direction and size bits, and the first opcode byte. The low three bits of that byte pick which pointer pair serves as destination and source. The counter drops by one on every element. Repeating operations end when the counter reaches zero. A repeating compare also ends early on the first element equal to the accumulator. The compare form leaves the carry flag untouched.

Top module: `blkxfer_engine`

## Requirements
- R1: After a synchronous active-low reset, all four pointers, the counter, the accumulator and the flags read zero, and `busy`, `done`, `mem_rd` and `mem_wr` are low.
- R2: While idle, a `cfg_we` cycle loads the register picked by `cfg_sel`: 0 pointer DE, 1 pointer HL, 2 pointer IX, 3 pointer IY, 4 counter, 5 accumulator, 6 flags (from `cfg_wdata[5:0]`). A `cfg_we` cycle while busy changes nothing.
- R3: The prefix byte is latched at start. When its bits [2:0] equal 5, IX is the destination and IY the source. Any other value makes DE the destination and HL the source.
- R4: A move element reads the source address in one cycle and writes the read data to the destination address in the next cycle. It then adjusts both pointers and decrements the counter by one.
- R5: A pointer steps by +1 (byte) or +2 (word) when `op_dec` is 0, and by -1 or -2 when `op_dec` is 1. The counter wraps modulo 2^16.
- R6: After a move element, N=0, H=0 and V=(counter != 0). S, Z and C keep their values. The flag bits are S=5, Z=4, H=3, V=2, N=1, C=0.
- R7: A compare element takes one read cycle and performs no write. It sets S to the result's top bit, Z=(result==0), H=(accumulator[3:0] < element[3:0]), N=1 and V=(counter != 0) from accumulator minus element. It keeps C, adjusts only the source pointer and decrements the counter.
- R8: A repeating move runs elements until the counter reaches zero.
- R9: A repeating compare runs elements until the counter reaches zero or an element equals the accumulator, whichever comes first.
- R10: A word compare uses all 16 accumulator bits and the 16-bit element at the source address (low byte at the lower address). A byte compare uses only the accumulator's low 8 bits and one byte.
- R11: `busy` is high from the cycle after `start` until the last element completes. `done` pulses for one cycle as `busy` falls. An operation takes 2 cycles per moved element or 1 cycle per compared element. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op_move | input | 1 | 1 = move, 0 = compare |
| op_repeat | input | 1 | 1 = repeating form |
| op_dec | input | 1 | 1 = pointers step downward |
| op_word | input | 1 | 1 = 16-bit elements, 0 = bytes |
| prefix | input | 8 | First opcode byte; bits [2:0] pick the pointer pair |
| cfg_we | input | 1 | Register load strobe (idle only) |
| cfg_sel | input | 3 | Register select for loads |
| cfg_wdata | input | 16 | Register load value |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read cycle |
| mem_wr | output | 1 | Memory write cycle |
| mem_word | output | 1 | Access is 16 bits wide |
| mem_wdata | output | 16 | Write data (low byte only for byte accesses) |
| mem_rdata | input | 16 | Read data, valid in the same cycle as `mem_rd` |
| ptr_de | output | 16 | Pointer DE |
| ptr_hl | output | 16 | Pointer HL |
| ptr_ix | output | 16 | Pointer IX |
| ptr_iy | output | 16 | Pointer IY |
| count | output | 16 | Element counter |
| acc | output | 16 | Accumulator |
| flags | output | 6 | {S,Z,H,V,N,C} |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench attacks prefix decoding with bytes that differ only outside bits [2:0]. A design that decoded the whole byte would update the wrong pointer pair. It runs a repeating compare whose match lands mid-run, and another that never matches. A design that ignored Z would overrun the match, and one that stopped on a stale flag would end early, which shows up as wrong counter and pointer values. The carry flag is preset before compares and S/Z before moves, so a design that cleared them would be caught. Byte and word compares run against an accumulator whose high byte differs. A `start` plus a configuration write injected mid-run must leave the accumulator and the cycle count unchanged.

// File: rtl/blkxfer_pkg.sv
// Shared types and encodings for the block move/compare sequencer.
// Assumes: flag bit order and register select codes are fixed by the brief.
package blkxfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bx_state_t;

    // register select codes for the load port
    localparam logic [2:0] SEL_DE    = 3'd0;
    localparam logic [2:0] SEL_HL    = 3'd1;
    localparam logic [2:0] SEL_IX    = 3'd2;
    localparam logic [2:0] SEL_IY    = 3'd3;
    localparam logic [2:0] SEL_COUNT = 3'd4;
    localparam logic [2:0] SEL_ACC   = 3'd5;
    localparam logic [2:0] SEL_FLAGS = 3'd6;

    // flag bit positions
    localparam int FL_C = 0;
    localparam int FL_N = 1;
    localparam int FL_V = 2;
    localparam int FL_H = 3;
    localparam int FL_Z = 4;
    localparam int FL_S = 5;
    localparam int FL_W = 6;

    // prefix low-bit code that selects the alternate pointer pair
    localparam logic [2:0] ALT_PAIR_CODE = 3'd5;
endpackage

// File: rtl/blkxfer_step.sv
// Pointer stepper: returns the pointer moved by one element in the chosen
// direction. Assumes the element size is 1 (byte) or 2 (word) address units.
module blkxfer_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic          dec,
    input  logic          word,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] amount;

    // pick the step size and apply it up or down
    always_comb begin
        amount = word ? AW'(2) : AW'(1);
        nxt    = dec ? (cur - amount) : (cur + amount);
    end
endmodule

// File: rtl/blkxfer_cmp.sv
// Compare unit: subtracts the element from the accumulator at byte or word
// width and returns the sign, zero and nibble-borrow results.
// Assumes DW is even; the byte width is DW/2.
module blkxfer_cmp #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    input  logic          word,
    output logic          neg,
    output logic          zero,
    output logic          half
);
    localparam int BW = DW / 2;

    logic [DW-1:0] l_m;
    logic [DW-1:0] r_m;
    logic [DW-1:0] diff;

    // narrow the operands to the element width and derive the flags
    always_comb begin
        l_m  = word ? lhs : {{(DW-BW){1'b0}}, lhs[BW-1:0]};
        r_m  = word ? rhs : {{(DW-BW){1'b0}}, rhs[BW-1:0]};
        diff = l_m - r_m;
        neg  = word ? diff[DW-1] : diff[BW-1];
        zero = word ? (diff == '0) : (diff[BW-1:0] == '0);
        half = (l_m[3:0] < r_m[3:0]);
    end
endmodule

// File: rtl/blkxfer_engine.sv
// Block move / block compare sequencer.
// Holds four pointers, a counter, an accumulator and a flag register, and
// steps through memory one element at a time. Move: read cycle then write
// cycle. Compare: one read cycle. Assumes memory read data is valid in the
// same cycle as mem_rd and that writes complete in the mem_wr cycle.
module blkxfer_engine
    import blkxfer_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_move,
    input  logic          op_repeat,
    input  logic          op_dec,
    input  logic          op_word,
    input  logic [7:0]    prefix,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          mem_word,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] ptr_de,
    output logic [AW-1:0] ptr_hl,
    output logic [AW-1:0] ptr_ix,
    output logic [AW-1:0] ptr_iy,
    output logic [CW-1:0] count,
    output logic [DW-1:0] acc,
    output logic [FL_W-1:0] flags,
    output logic          busy,
    output logic          done
);
    localparam int BW    = DW / 2;
    localparam int NPTR  = 4;
    localparam int PIW   = $clog2(NPTR);

    bx_state_t       state_q;
    logic            mv_q, rep_q, dec_q, wd_q, alt_q;
    logic [DW-1:0]   hold_q;
    logic [AW-1:0]   ptr_q [NPTR];
    logic [CW-1:0]   cnt_q;
    logic [DW-1:0]   acc_q;
    logic [FL_W-1:0] flg_q;

    logic [PIW-1:0]  dst_idx, src_idx;
    logic [AW-1:0]   dst_cur, src_cur, dst_nxt, src_nxt;
    logic [CW-1:0]   cnt_nxt;
    logic            more;
    logic            c_neg, c_zero, c_half;
    logic            step_cmp, step_wr, upd_src, cfg_ok;
    logic            fin_cmp, fin_wr;

    // pick destination/source pointer slots from the latched pair select
    always_comb begin
        dst_idx = alt_q ? PIW'(2) : PIW'(0);
        src_idx = alt_q ? PIW'(3) : PIW'(1);
        dst_cur = ptr_q[dst_idx];
        src_cur = ptr_q[src_idx];
    end

    blkxfer_step #(.AW(AW)) u_dst_step (.cur(dst_cur), .dec(dec_q), .word(wd_q), .nxt(dst_nxt));
    blkxfer_step #(.AW(AW)) u_src_step (.cur(src_cur), .dec(dec_q), .word(wd_q), .nxt(src_nxt));

    blkxfer_cmp #(.DW(DW)) u_cmp (
        .lhs(acc_q), .rhs(mem_rdata), .word(wd_q),
        .neg(c_neg), .zero(c_zero), .half(c_half)
    );

    // element-step strobes, counter lookahead and termination tests
    always_comb begin
        cnt_nxt  = cnt_q - CW'(1);
        more     = (cnt_nxt != '0);
        step_cmp = (state_q == ST_READ) && !mv_q;
        step_wr  = (state_q == ST_WRITE);
        upd_src  = step_cmp || step_wr;
        cfg_ok   = cfg_we && (state_q == ST_IDLE);
        fin_cmp  = step_cmp && !(rep_q && more && !c_zero);
        fin_wr   = step_wr && !(rep_q && more);
    end

    // memory port drive
    always_comb begin
        mem_rd    = (state_q == ST_READ);
        mem_wr    = (state_q == ST_WRITE);
        mem_addr  = mem_wr ? dst_cur : src_cur;
        mem_word  = wd_q;
        mem_wdata = wd_q ? hold_q : {{(DW-BW){1'b0}}, hold_q[BW-1:0]};
    end

    // sequencer: latch the operation, walk read/write cycles, flag completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
            mv_q    <= 1'b0;
            rep_q   <= 1'b0;
            dec_q   <= 1'b0;
            wd_q    <= 1'b0;
            alt_q   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    mv_q    <= op_move;
                    rep_q   <= op_repeat;
                    dec_q   <= op_dec;
                    wd_q    <= op_word;
                    alt_q   <= (prefix[2:0] == ALT_PAIR_CODE);
                    state_q <= ST_READ;
                end
                ST_READ: begin
                    if (mv_q) begin
                        state_q <= ST_WRITE;
                    end else if (fin_cmp) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end
                end
                ST_WRITE: begin
                    if (fin_wr) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end else begin
                        state_q <= ST_READ;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // capture the element read during a move
    always_ff @(posedge clk) begin
        if (!rst_n)                            hold_q <= '0;
        else if (state_q == ST_READ && mv_q)   hold_q <= mem_rdata;
    end

    // pointer registers: idle loads, then destination/source stepping
    for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_q[gi] <= '0;
            else if (cfg_ok && cfg_sel == 3'(gi))
                ptr_q[gi] <= AW'(cfg_wdata);
            else if (step_wr && dst_idx == PIW'(gi))
                ptr_q[gi] <= dst_nxt;
            else if (upd_src && src_idx == PIW'(gi))
                ptr_q[gi] <= src_nxt;
        end
    end

    // counter: idle load or one decrement per element
    always_ff @(posedge clk) begin
        if (!rst_n)                            cnt_q <= '0;
        else if (cfg_ok && cfg_sel == SEL_COUNT) cnt_q <= CW'(cfg_wdata);
        else if (upd_src)                      cnt_q <= cnt_nxt;
    end

    // accumulator: idle load only
    always_ff @(posedge clk) begin
        if (!rst_n)                            acc_q <= '0;
        else if (cfg_ok && cfg_sel == SEL_ACC) acc_q <= cfg_wdata;
    end

    // flags: idle load, move update, compare update (carry always kept)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else if (cfg_ok && cfg_sel == SEL_FLAGS) begin
            flg_q <= cfg_wdata[FL_W-1:0];
        end else if (step_wr) begin
            flg_q[FL_N] <= 1'b0;
            flg_q[FL_H] <= 1'b0;
            flg_q[FL_V] <= more;
        end else if (step_cmp) begin
            flg_q[FL_S] <= c_neg;
            flg_q[FL_Z] <= c_zero;
            flg_q[FL_H] <= c_half;
            flg_q[FL_N] <= 1'b1;
            flg_q[FL_V] <= more;
        end
    end

    assign ptr_de = ptr_q[0];
    assign ptr_hl = ptr_q[1];
    assign ptr_ix = ptr_q[2];
    assign ptr_iy = ptr_q[3];
    assign count  = cnt_q;
    assign acc    = acc_q;
    assign flags  = flg_q;
    assign busy   = (state_q != ST_IDLE);

    // ---------------- assertions ----------------
    p_rdwr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_wr_after_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd));

    p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || (mem_rd && !mv_q)) |=> (count == CW'($past(count) - CW'(1))));

    p_carry_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mv_q) |=> (flags[FL_C] == $past(flags[FL_C])));

    p_cmp_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mv_q) |-> !mem_wr);

    p_acc_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(acc));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));
endmodule

// File: tb/blkxfer_engine_test.sv
// Scoreboard bench: the driver task models each operation from the brief,
// queues the expected memory writes, and a monitor pops them as they occur.
module blkxfer_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, op_move = 1'b0, op_repeat = 1'b0, op_dec = 1'b0, op_word = 1'b0;
    logic [7:0]  prefix = 8'h00;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [15:0] cfg_wdata = 16'h0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr, mem_word;
    logic [15:0] ptr_de, ptr_hl, ptr_ix, ptr_iy, count, acc;
    logic [5:0]  flags;
    logic        busy, done;

    always #5 clk = ~clk;

    blkxfer_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_move(op_move), .op_repeat(op_repeat),
        .op_dec(op_dec), .op_word(op_word), .prefix(prefix), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_word(mem_word), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ptr_de(ptr_de), .ptr_hl(ptr_hl), .ptr_ix(ptr_ix), .ptr_iy(ptr_iy), .count(count),
        .acc(acc), .flags(flags), .busy(busy), .done(done)
    );

    logic [7:0] mem  [0:4095];
    logic [7:0] smem [0:4095];

    function automatic logic [15:0] rd16(input logic [15:0] a);
        rd16 = {mem[12'(a + 16'd1)], mem[12'(a)]};
    endfunction
    assign mem_rdata = rd16(mem_addr);

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    typedef struct { logic [15:0] a; logic [15:0] d; } wr_item_t;
    wr_item_t exp_q[$];

    // monitor: pop and compare every write, then apply it to the memory model
    always @(negedge clk) begin
        if (mem_wr) begin
            if (exp_q.size() == 0) begin
                chk("R4 unexpected write", {16'h0, mem_addr}, 32'hFFFF_FFFF);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                chk("R4 write address", {16'h0, mem_addr}, {16'h0, it.a});
                chk("R4 write data", {16'h0, mem_wdata}, {16'h0, it.d});
            end
            mem[12'(mem_addr)] = mem_wdata[7:0];
            if (mem_word) mem[12'(mem_addr + 16'd1)] = mem_wdata[15:8];
        end
    end

    // reference register state
    logic [15:0] m_ptr [4];
    logic [15:0] m_cnt, m_acc;
    logic [5:0]  m_flg;

    task automatic poke(input logic [15:0] a, input logic [7:0] v);
        mem[12'(a)]  = v;
        smem[12'(a)] = v;
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            3'd0, 3'd1, 3'd2, 3'd3: m_ptr[sel[1:0]] = v;
            3'd4: m_cnt = v;
            3'd5: m_acc = v;
            3'd6: m_flg = v[5:0];
            default: ;
        endcase
    endtask

    task automatic check_regs(input string tag);
        chk({tag, " DE"},    {16'h0, ptr_de}, {16'h0, m_ptr[0]});
        chk({tag, " HL"},    {16'h0, ptr_hl}, {16'h0, m_ptr[1]});
        chk({tag, " IX"},    {16'h0, ptr_ix}, {16'h0, m_ptr[2]});
        chk({tag, " IY"},    {16'h0, ptr_iy}, {16'h0, m_ptr[3]});
        chk({tag, " count"}, {16'h0, count},  {16'h0, m_cnt});
        chk({tag, " acc"},   {16'h0, acc},    {16'h0, m_acc});
        chk({tag, " flags"}, {26'h0, flags},  {26'h0, m_flg});
    endtask

    // driver: model the operation, queue expected writes, run it, compare
    task automatic run_op(input logic mv, input logic rep, input logic dec, input logic wd,
                          input logic [7:0] pre, input logic poke_busy, input string tag);
        int di, si, cyc, n;
        logic [15:0] st, d, a, r;
        logic go;
        di  = (pre[2:0] == 3'd5) ? 2 : 0;
        si  = (pre[2:0] == 3'd5) ? 3 : 1;
        st  = wd ? 16'd2 : 16'd1;
        cyc = 0;
        do begin
            d = {smem[12'(m_ptr[si] + 16'd1)], smem[12'(m_ptr[si])]};
            if (!wd) d = {8'h0, d[7:0]};
            if (mv) begin
                exp_q.push_back('{a: m_ptr[di], d: d});
                smem[12'(m_ptr[di])] = d[7:0];
                if (wd) smem[12'(m_ptr[di] + 16'd1)] = d[15:8];
                m_ptr[di] = dec ? m_ptr[di] - st : m_ptr[di] + st;
                m_ptr[si] = dec ? m_ptr[si] - st : m_ptr[si] + st;
                m_cnt = m_cnt - 16'd1;
                m_flg[1] = 1'b0; m_flg[3] = 1'b0; m_flg[2] = (m_cnt != 0);
                cyc += 2;
                go = rep && (m_cnt != 0);
            end else begin
                a = wd ? m_acc : {8'h0, m_acc[7:0]};
                r = a - d;
                m_flg[5] = wd ? r[15] : r[7];
                m_flg[4] = wd ? (r == 0) : (r[7:0] == 0);
                m_flg[3] = (a[3:0] < d[3:0]);
                m_flg[1] = 1'b1;
                m_ptr[si] = dec ? m_ptr[si] - st : m_ptr[si] + st;
                m_cnt = m_cnt - 16'd1;
                m_flg[2] = (m_cnt != 0);
                cyc += 1;
                go = rep && (m_cnt != 0) && !m_flg[4];
            end
        end while (go);

        @(negedge clk);
        start = 1'b1; op_move = mv; op_repeat = rep; op_dec = dec; op_word = wd; prefix = pre;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        chk({tag, " R11 busy after start"}, {31'h0, busy}, 32'h1);
        while (!done && n < 5000) begin
            if (poke_busy && n == 3) begin
                cfg_we = 1'b1; cfg_sel = 3'd5; cfg_wdata = 16'hAAAA;
                start = 1'b1; op_move = ~mv;
            end else begin
                cfg_we = 1'b0; start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        cfg_we = 1'b0; start = 1'b0;
        chk({tag, " R11 cycles"}, n, cyc + 1);
        chk({tag, " R11 busy low at done"}, {31'h0, busy}, 32'h0);
        check_regs(tag);
        chk({tag, " R4 all writes seen"}, exp_q.size(), 0);
        @(negedge clk);
        chk({tag, " R11 done one cycle"}, {30'h0, done, busy}, 32'h0);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) begin
            mem[i]  = 8'(i * 7 + 3);
            smem[i] = 8'(i * 7 + 3);
        end
        for (int i = 0; i < 4; i++) m_ptr[i] = 16'h0;
        m_cnt = 0; m_acc = 0; m_flg = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_regs("R1 reset");
        chk("R1 reset busy/done/rd/wr", {28'h0, busy, done, mem_rd, mem_wr}, 32'h0);

        // R2: register loads while idle
        cfg(3'd0, 16'h0100); cfg(3'd1, 16'h0200); cfg(3'd2, 16'h0300); cfg(3'd3, 16'h0400);
        cfg(3'd4, 16'h0001); cfg(3'd5, 16'h1234); cfg(3'd6, 16'h0031);
        check_regs("R2 load");

        // R4 R5 R6: single byte move upward on DE/HL, S/Z/C preset and kept
        run_op(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, "R4 R5 R6 byte move");

        // R3 R5: single word move downward; prefix low bits 5 picks IX/IY
        cfg(3'd4, 16'h0003);
        run_op(1'b1, 1'b0, 1'b1, 1'b1, 8'h85, 1'b0, "R3 R5 word move alt");

        // R3 R8: repeating byte move, prefix 0x84 keeps DE/HL
        cfg(3'd4, 16'h0004);
        run_op(1'b1, 1'b1, 1'b0, 1'b0, 8'h84, 1'b0, "R3 R8 repeat move");

        // R7: single byte compare with carry preset
        cfg(3'd6, 16'h0001); cfg(3'd1, 16'h0500); cfg(3'd4, 16'h0002);
        poke(16'h0500, 8'h48);
        run_op(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, "R7 byte compare");

        // R9: repeating compare stops on match at third element
        cfg(3'd1, 16'h0600); cfg(3'd4, 16'h0008); cfg(3'd5, 16'h1235);
        poke(16'h0600, 8'h10); poke(16'h0601, 8'h11); poke(16'h0602, 8'h35);
        run_op(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, "R9 compare match");

        // R9: repeating compare downward, no match, counter exhausted
        cfg(3'd1, 16'h0702); cfg(3'd4, 16'h0003);
        poke(16'h0700, 8'h00); poke(16'h0701, 8'h00); poke(16'h0702, 8'h00);
        run_op(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R9 compare exhaust");

        // R10: word compare, low byte matches but high byte differs
        cfg(3'd1, 16'h0800); cfg(3'd4, 16'h0001);
        poke(16'h0800, 8'h35); poke(16'h0801, 8'h00);
        run_op(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, "R10 word compare");
        chk("R10 word compare Z clear", {31'h0, flags[4]}, 32'h0);

        // R10: byte compare at the same place uses only the low byte
        cfg(3'd1, 16'h0800); cfg(3'd4, 16'h0001);
        run_op(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, "R10 byte compare");
        chk("R10 byte compare Z set", {31'h0, flags[4]}, 32'h1);

        // R10: word match needs both bytes
        cfg(3'd1, 16'h0810); cfg(3'd4, 16'h0002);
        poke(16'h0810, 8'h35); poke(16'h0811, 8'h12);
        run_op(1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, "R10 word match");

        // R2 R11: load and start during a repeating move are ignored
        cfg(3'd0, 16'h0900); cfg(3'd1, 16'h0A00); cfg(3'd4, 16'h0006);
        run_op(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, "R2 R11 busy ignore");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule